// File: doc/BRIEF.md
# Indirect PCI Configuration and I/O Access Port

This block gives a processor a narrow register window through which it can start PCI configuration cycles and PCI I/O cycles without a direct mapping of either space. Software first loads a 32-bit target address into a pointer register. It then reads or writes one of two 4-byte data windows, one for configuration space and one for I/O space. Each data-window access becomes a single downstream cycle. The cycle carries a target address, byte enables, a direction flag and lane-aligned write data. The block waits for the downstream completion and then answers the processor.

Accesses of 1, 2 or 4 bytes may be made at any byte offset inside a window, but only where the size fits the offset's natural alignment. Anything else is refused at once with an error response, and no downstream cycle is started. The configuration window moves data in little-endian lane order. The I/O window moves data in big-endian order, so the most significant byte of the processor's value lands on the lowest-addressed lane. The pointer register is shared by both windows. Its enable bit is not checked, so any stored value is used as-is. I/O addresses are cut down to the width of the I/O space.

Top module: `pci_ind_port`

## Requirements
- R1: After reset, hst_ready is 1 and dn_valid is 0, and a read of the pointer register returns 0.
- R2: The pointer register sits at offset 0x064 and accepts only hst_size=4. A write stores hst_wdata with bits [1:0] forced to 0, and a read returns the stored value. Any other size at 0x064, or any access at 0x065 to 0x067, gives hst_rsp_err=1 and leaves the register unchanged.
- R3: An access at offsets 0x068 to 0x06B starts a configuration cycle (dn_is_io=0). Its dn_addr is the pointer value ORed with offset[1:0]. The cycle is issued even when pointer bit 31 is 0 or 1.
- R4: An access at offsets 0x06C to 0x06F starts an I/O cycle (dn_is_io=1). Its dn_addr is (pointer + offset[1:0]) modulo 2^IO_AW, with all bits at IO_AW and above equal to 0.
- R5: hst_size is a byte count. Counting the byte offset o inside a window, size 1 is legal at any o, size 2 at o=0 or o=2, and size 4 only at o=0. Illegal sizes include any size other than 1, 2 or 4, and any offset outside 0x064 to 0x06F is also refused. A refused access gives hst_rsp_valid=1 and hst_rsp_err=1 in the cycle after it is accepted, and it starts no downstream cycle.
- R6: dn_be bit k is 1 exactly when byte lane k (bits 8k+7:8k) lies in [o, o+size).
- R7: In configuration cycles, byte i of the right-justified host value travels on lane o+i, in both directions. Read data is zero-extended above the access size, and unused write lanes are 0.
- R8: In I/O cycles, byte i of the host value travels on lane o+size-1-i. The most significant byte sits on the lowest lane.
- R9: While dn_valid=1 and dn_ready=0, dn_valid and every dn_* field hold steady. hst_ready is 0 from acceptance until the response. The response (hst_rsp_valid, with hst_rsp_err=0) comes one cycle after dn_rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_req | input | 1 | Host access request, taken when hst_ready is 1 |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_offset | input | OFF_W | Byte offset of the access |
| hst_size | input | 3 | Access size in bytes |
| hst_wdata | input | 32 | Right-justified write value |
| hst_ready | output | 1 | Block idle, able to take a request |
| hst_rsp_valid | output | 1 | One-cycle response strobe |
| hst_rsp_err | output | 1 | Access refused |
| hst_rdata | output | 32 | Right-justified read value |
| dn_valid | output | 1 | Downstream cycle request |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_is_io | output | 1 | 1 = I/O cycle, 0 = configuration cycle |
| dn_we | output | 1 | 1 = write cycle |
| dn_addr | output | 32 | Cycle address |
| dn_be | output | 4 | Byte lane enables |
| dn_wdata | output | 32 | Lane-aligned write data |
| dn_rsp_valid | input | 1 | Downstream completion strobe |
| dn_rdata | input | 32 | Lane-aligned read data, valid with dn_rsp_valid |

## Verification
The bench uses the default OFF_W=12 and IO_AW=16. It loads a pointer whose bit 31 is set and whose bit 16 lies above the I/O width. This shows that configuration cycles keep the full OR-ed address while I/O cycles truncate theirs. A fixed downstream read pattern with a distinct byte on every lane makes both byte orders and the zero extension visible. The downstream ready delay is raised to three cycles for one access, to exercise holding the request.

// File: rtl/pci_ind_pkg.sv
// Shared types and helper functions for the indirect PCI access port.
// Assumes a 4-byte downstream data path with byte lanes 0..3.
package pci_ind_pkg;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_PTR  = 2'd1,
        WIN_CFG  = 2'd2,
        WIN_IO   = 2'd3
    } win_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } st_e;

    // Natural-alignment rule for a data-window access.
    function automatic logic size_fits(input logic [1:0] off, input logic [2:0] sz);
        case (sz)
            3'd1:    size_fits = 1'b1;
            3'd2:    size_fits = (off[0] == 1'b0);
            3'd4:    size_fits = (off == 2'd0);
            default: size_fits = 1'b0;
        endcase
    endfunction

    // Byte lanes covered by an access of sz bytes starting at lane off.
    function automatic logic [3:0] lane_mask(input logic [1:0] off, input logic [2:0] sz);
        case (sz)
            3'd1:    lane_mask = 4'b0001 << off;
            3'd2:    lane_mask = 4'b0011 << off;
            3'd4:    lane_mask = 4'b1111;
            default: lane_mask = 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/pci_ind_decode.sv
// Offset decoder: picks the window an access falls in, decides if the
// size is legal there and derives its byte enables. Purely combinational.
// Assumes every window is 4-byte aligned.
module pci_ind_decode
    import pci_ind_pkg::*;
#(
    parameter int OFF_W   = 12,
    parameter int PTR_OFS = 'h064,
    parameter int CFG_OFS = 'h068,
    parameter int IO_OFS  = 'h06C
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [2:0]       size,
    output win_e             win,
    output logic             legal,
    output logic [3:0]       be
);

    localparam logic [OFF_W-1:0] PTR_O = OFF_W'(PTR_OFS);
    localparam logic [OFF_W-1:0] CFG_O = OFF_W'(CFG_OFS);
    localparam logic [OFF_W-1:0] IO_O  = OFF_W'(IO_OFS);

    logic [1:0] lo;
    assign lo = offset[1:0];

    // Window match on the word part of the offset.
    always_comb begin
        if (offset[OFF_W-1:2] == PTR_O[OFF_W-1:2])      win = WIN_PTR;
        else if (offset[OFF_W-1:2] == CFG_O[OFF_W-1:2]) win = WIN_CFG;
        else if (offset[OFF_W-1:2] == IO_O[OFF_W-1:2])  win = WIN_IO;
        else                                             win = WIN_NONE;
    end

    // Legality: pointer wants a whole word, data windows want alignment.
    always_comb begin
        case (win)
            WIN_PTR:        legal = (lo == 2'd0) && (size == 3'd4);
            WIN_CFG, WIN_IO: legal = size_fits(lo, size);
            default:        legal = 1'b0;
        endcase
    end

    assign be = lane_mask(lo, size);

endmodule

// File: rtl/pci_ind_lane.sv
// Byte-lane steering between right-justified host values and lane-aligned
// downstream data, in little-endian (configuration) or big-endian (I/O)
// order. Write and read paths have separate controls because the read
// path works on the request captured earlier. Purely combinational.
module pci_ind_lane #(
    parameter int LANES = 4
) (
    input  logic [1:0]         w_off,
    input  logic [2:0]         w_size,
    input  logic               w_big,
    input  logic [8*LANES-1:0] w_value,
    output logic [8*LANES-1:0] w_lanes,
    input  logic [1:0]         r_off,
    input  logic [2:0]         r_size,
    input  logic               r_big,
    input  logic [8*LANES-1:0] r_lanes,
    output logic [8*LANES-1:0] r_value
);

    // Write path: each lane picks the host byte that belongs on it.
    for (genvar k = 0; k < LANES; k++) begin : g_wlane
        logic [2:0] idx;
        logic [2:0] pos;
        logic       hit;
        logic [7:0] byte_q;
        always_comb begin
            idx    = 3'(k) - {1'b0, w_off};
            hit    = (3'(k) >= {1'b0, w_off}) && (idx < w_size);
            pos    = w_big ? (w_size - 3'd1 - idx) : idx;
            byte_q = hit ? w_value[8*pos[1:0] +: 8] : 8'h00;
        end
        assign w_lanes[8*k +: 8] = byte_q;
    end

    // Read path: gather the covered lanes into a right-justified value.
    always_comb begin
        r_value = '0;
        for (int i = 0; i < LANES; i++) begin
            logic [1:0] lane;
            logic [2:0] pos;
            lane = r_off + 2'(i);
            pos  = r_big ? (r_size - 3'd1 - 3'(i)) : 3'(i);
            if (3'(i) < r_size) begin
                r_value[8*pos[1:0] +: 8] = r_lanes[8*lane +: 8];
            end
        end
    end

endmodule

// File: rtl/pci_ind_ctrl.sv
// Sequencer: holds the pointer register, answers pointer and refused
// accesses directly and runs one downstream cycle per data-window access.
// Assumes the host issues a request only while hst_ready is high.
module pci_ind_ctrl
    import pci_ind_pkg::*;
#(
    parameter int IO_AW = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hst_req,
    input  logic        hst_we,
    input  logic [1:0]  off_lo,
    input  logic [2:0]  hst_size,
    input  logic [31:0] hst_wdata,
    input  win_e        win,
    input  logic        legal,
    input  logic [3:0]  be,
    input  logic [31:0] steer_wdata,
    input  logic [31:0] steer_rdata,
    output logic        hst_ready,
    output logic        hst_rsp_valid,
    output logic        hst_rsp_err,
    output logic [31:0] hst_rdata,
    output logic        dn_valid,
    input  logic        dn_ready,
    output logic        dn_is_io,
    output logic        dn_we,
    output logic [31:0] dn_addr,
    output logic [3:0]  dn_be,
    output logic [31:0] dn_wdata,
    input  logic        dn_rsp_valid,
    output logic [1:0]  cap_off,
    output logic [2:0]  cap_size
);

    localparam logic [31:0] IO_MASK = (IO_AW >= 32) ? 32'hFFFF_FFFF
                                                    : ((32'd1 << IO_AW) - 32'd1);

    st_e         st;
    logic [31:0] ptr_q;
    logic [31:0] cfg_addr;
    logic [31:0] io_addr;

    // Target addresses: configuration ORs the offset, I/O adds and truncates.
    always_comb begin
        cfg_addr = ptr_q | {30'd0, off_lo};
        io_addr  = (ptr_q + {30'd0, off_lo}) & IO_MASK;
    end

    // Main state, pointer register, downstream request and host response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st            <= ST_IDLE;
            ptr_q         <= '0;
            hst_rsp_valid <= 1'b0;
            hst_rsp_err   <= 1'b0;
            hst_rdata     <= '0;
            dn_is_io      <= 1'b0;
            dn_we         <= 1'b0;
            dn_addr       <= '0;
            dn_be         <= '0;
            dn_wdata      <= '0;
            cap_off       <= '0;
            cap_size      <= '0;
        end else begin
            hst_rsp_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (hst_req) begin
                        if (!legal) begin
                            hst_rsp_valid <= 1'b1;
                            hst_rsp_err   <= 1'b1;
                            hst_rdata     <= '0;
                        end else if (win == WIN_PTR) begin
                            hst_rsp_valid <= 1'b1;
                            hst_rsp_err   <= 1'b0;
                            hst_rdata     <= hst_we ? 32'd0 : ptr_q;
                            if (hst_we) begin
                                ptr_q <= {hst_wdata[31:2], 2'b00};
                            end
                        end else begin
                            dn_is_io <= (win == WIN_IO);
                            dn_we    <= hst_we;
                            dn_addr  <= (win == WIN_IO) ? io_addr : cfg_addr;
                            dn_be    <= be;
                            dn_wdata <= hst_we ? steer_wdata : 32'd0;
                            cap_off  <= off_lo;
                            cap_size <= hst_size;
                            st       <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (dn_ready) begin
                        st <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (dn_rsp_valid) begin
                        hst_rsp_valid <= 1'b1;
                        hst_rsp_err   <= 1'b0;
                        hst_rdata     <= dn_we ? 32'd0 : steer_rdata;
                        st            <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign hst_ready = (st == ST_IDLE);
    assign dn_valid  = (st == ST_ISSUE);

endmodule

// File: rtl/pci_ind_port.sv
// Top of the indirect PCI configuration / I/O access port. Ties the
// offset decoder, the lane steering and the sequencer together.
// Assumes one outstanding access at a time.
module pci_ind_port
    import pci_ind_pkg::*;
#(
    parameter int OFF_W = 12,
    parameter int IO_AW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hst_req,
    input  logic             hst_we,
    input  logic [OFF_W-1:0] hst_offset,
    input  logic [2:0]       hst_size,
    input  logic [31:0]      hst_wdata,
    output logic             hst_ready,
    output logic             hst_rsp_valid,
    output logic             hst_rsp_err,
    output logic [31:0]      hst_rdata,
    output logic             dn_valid,
    input  logic             dn_ready,
    output logic             dn_is_io,
    output logic             dn_we,
    output logic [31:0]      dn_addr,
    output logic [3:0]       dn_be,
    output logic [31:0]      dn_wdata,
    input  logic             dn_rsp_valid,
    input  logic [31:0]      dn_rdata
);

    win_e        win;
    logic        legal;
    logic [3:0]  be;
    logic [31:0] steer_wdata;
    logic [31:0] steer_rdata;
    logic [1:0]  cap_off;
    logic [2:0]  cap_size;

    pci_ind_decode #(.OFF_W(OFF_W)) u_decode (
        .offset (hst_offset),
        .size   (hst_size),
        .win    (win),
        .legal  (legal),
        .be     (be)
    );

    pci_ind_lane #(.LANES(4)) u_lane (
        .w_off   (hst_offset[1:0]),
        .w_size  (hst_size),
        .w_big   (win == WIN_IO),
        .w_value (hst_wdata),
        .w_lanes (steer_wdata),
        .r_off   (cap_off),
        .r_size  (cap_size),
        .r_big   (dn_is_io),
        .r_lanes (dn_rdata),
        .r_value (steer_rdata)
    );

    pci_ind_ctrl #(.IO_AW(IO_AW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .hst_req       (hst_req),
        .hst_we        (hst_we),
        .off_lo        (hst_offset[1:0]),
        .hst_size      (hst_size),
        .hst_wdata     (hst_wdata),
        .win           (win),
        .legal         (legal),
        .be            (be),
        .steer_wdata   (steer_wdata),
        .steer_rdata   (steer_rdata),
        .hst_ready     (hst_ready),
        .hst_rsp_valid (hst_rsp_valid),
        .hst_rsp_err   (hst_rsp_err),
        .hst_rdata     (hst_rdata),
        .dn_valid      (dn_valid),
        .dn_ready      (dn_ready),
        .dn_is_io      (dn_is_io),
        .dn_we         (dn_we),
        .dn_addr       (dn_addr),
        .dn_be         (dn_be),
        .dn_wdata      (dn_wdata),
        .dn_rsp_valid  (dn_rsp_valid),
        .cap_off       (cap_off),
        .cap_size      (cap_size)
    );

endmodule

// File: rtl/pci_ind_port_chk.sv
// Property checker for the indirect access port, attached by bind.
// Watches the top-level ports only.
module pci_ind_port_chk #(
    parameter int OFF_W = 12,
    parameter int IO_AW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hst_req,
    input logic [OFF_W-1:0] hst_offset,
    input logic [2:0]       hst_size,
    input logic             hst_ready,
    input logic             hst_rsp_valid,
    input logic             hst_rsp_err,
    input logic             dn_valid,
    input logic             dn_ready,
    input logic             dn_is_io,
    input logic [31:0]      dn_addr,
    input logic [3:0]       dn_be,
    input logic [31:0]      dn_wdata,
    input logic             dn_rsp_valid
);

    logic in_data_win;
    logic in_ptr_win;
    logic ok_now;

    // Independent statement of which accesses are allowed.
    always_comb begin
        in_ptr_win  = (hst_offset == OFF_W'('h064));
        in_data_win = (hst_offset >= OFF_W'('h068)) && (hst_offset <= OFF_W'('h06F));
        ok_now      = (in_ptr_win && hst_size == 3'd4) ||
                      (in_data_win && ((hst_size == 3'd1) ||
                                       (hst_size == 3'd2 && !hst_offset[0]) ||
                                       (hst_size == 3'd4 && hst_offset[1:0] == 2'd0)));
    end

    AST_REFUSE_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hst_req && hst_ready && !ok_now |=> hst_rsp_valid && hst_rsp_err && !dn_valid); // R5

    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> (($countones(dn_be) == 1) || ($countones(dn_be) == 2) ||
                      ($countones(dn_be) == 4)) && dn_be[dn_addr[1:0]]); // R6

    AST_IO_ADDR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && dn_is_io |-> ((dn_addr >> IO_AW) == 32'd0)); // R4

    AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_be) &&
                                  $stable(dn_wdata) && $stable(dn_is_io)); // R9

    AST_BUSY_WHEN_ISSUING: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> !hst_ready); // R9

    AST_RSP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_rsp_valid && !hst_ready |=> hst_rsp_valid && !hst_rsp_err); // R9

endmodule

bind pci_ind_port pci_ind_port_chk #(.OFF_W(OFF_W), .IO_AW(IO_AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hst_req       (hst_req),
    .hst_offset    (hst_offset),
    .hst_size      (hst_size),
    .hst_ready     (hst_ready),
    .hst_rsp_valid (hst_rsp_valid),
    .hst_rsp_err   (hst_rsp_err),
    .dn_valid      (dn_valid),
    .dn_ready      (dn_ready),
    .dn_is_io      (dn_is_io),
    .dn_addr       (dn_addr),
    .dn_be         (dn_be),
    .dn_wdata      (dn_wdata),
    .dn_rsp_valid  (dn_rsp_valid)
);

// File: tb/test_pci_ind_port.sv
// Directed bench for the indirect PCI access port.
module test_pci_ind_port;

    localparam int OFF_W = 12;
    localparam int IO_AW = 16;
    localparam logic [31:0] RD_PAT = 32'hA1B2C3D4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hst_req = 1'b0;
    logic             hst_we = 1'b0;
    logic [OFF_W-1:0] hst_offset = '0;
    logic [2:0]       hst_size = 3'd4;
    logic [31:0]      hst_wdata = '0;
    logic             hst_ready;
    logic             hst_rsp_valid;
    logic             hst_rsp_err;
    logic [31:0]      hst_rdata;
    logic             dn_valid;
    logic             dn_ready = 1'b0;
    logic             dn_is_io;
    logic             dn_we;
    logic [31:0]      dn_addr;
    logic [3:0]       dn_be;
    logic [31:0]      dn_wdata;
    logic             dn_rsp_valid = 1'b0;
    logic [31:0]      dn_rdata = RD_PAT;

    int checks = 0;
    int failures = 0;
    int dn_count = 0;
    int rdy_delay = 0;
    logic        cap_io, cap_we;
    logic [31:0] cap_addr, cap_wdata;
    logic [3:0]  cap_be;
    logic [31:0] rd;
    logic        er;
    logic        saw_busy;
    logic        hold_bad;

    always #5 clk = ~clk;

    pci_ind_port #(.OFF_W(OFF_W), .IO_AW(IO_AW)) i_pci_ind_port (
        .clk(clk), .rst_n(rst_n),
        .hst_req(hst_req), .hst_we(hst_we), .hst_offset(hst_offset),
        .hst_size(hst_size), .hst_wdata(hst_wdata),
        .hst_ready(hst_ready), .hst_rsp_valid(hst_rsp_valid),
        .hst_rsp_err(hst_rsp_err), .hst_rdata(hst_rdata),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_is_io(dn_is_io),
        .dn_we(dn_we), .dn_addr(dn_addr), .dn_be(dn_be), .dn_wdata(dn_wdata),
        .dn_rsp_valid(dn_rsp_valid), .dn_rdata(dn_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Downstream model: optional ready delay, then completion two cycles later.
    initial begin
        forever begin
            @(negedge clk);
            if (dn_valid) begin
                logic [31:0] a0;
                a0 = dn_addr;
                for (int i = 0; i < rdy_delay; i++) begin
                    @(negedge clk);
                    if (!dn_valid || dn_addr !== a0) hold_bad = 1'b1;
                end
                dn_ready  = 1'b1;
                cap_io    = dn_is_io;
                cap_we    = dn_we;
                cap_addr  = dn_addr;
                cap_be    = dn_be;
                cap_wdata = dn_wdata;
                dn_count++;
                @(negedge clk);
                dn_ready = 1'b0;
                @(negedge clk);
                dn_rsp_valid = 1'b1;
                @(negedge clk);
                dn_rsp_valid = 1'b0;
            end
        end
    end

    // One host access; returns read data and error flag.
    task automatic access(input logic we, input int off, input int sz,
                          input logic [31:0] wd, output logic [31:0] rdat, output logic err);
        int tmo;
        @(negedge clk);
        hst_req    = 1'b1;
        hst_we     = we;
        hst_offset = OFF_W'(off);
        hst_size   = 3'(sz);
        hst_wdata  = wd;
        saw_busy   = 1'b0;
        tmo = 0;
        do begin
            @(negedge clk);
            hst_req = 1'b0;
            if (!hst_ready) saw_busy = 1'b1;
            tmo++;
        end while (!hst_rsp_valid && tmo < 200);
        if (tmo >= 200) begin
            failures++;
            $display("FAIL R9 access timeout actual=%0d expected<200", tmo);
        end
        rdat = hst_rdata;
        err  = hst_rsp_err;
    endtask

    task automatic t_reset();
        chk("R1 hst_ready", {31'd0, hst_ready}, 32'd1);
        chk("R1 dn_valid", {31'd0, dn_valid}, 32'd0);
        access(1'b0, 'h064, 4, 0, rd, er);
        chk("R1 pointer reads 0", rd, 32'd0);
    endtask

    task automatic t_pointer();
        access(1'b1, 'h064, 4, 32'h8001_2347, rd, er);
        chk("R2 write ok", {31'd0, er}, 32'd0);
        access(1'b0, 'h064, 4, 0, rd, er);
        chk("R2 low bits cleared", rd, 32'h8001_2344);
        access(1'b1, 'h064, 2, 32'hFFFF_FFFF, rd, er);
        chk("R2 halfword refused", {31'd0, er}, 32'd1);
        access(1'b1, 'h065, 1, 32'hFF, rd, er);
        chk("R2 byte at 0x065 refused", {31'd0, er}, 32'd1);
        access(1'b0, 'h064, 4, 0, rd, er);
        chk("R2 pointer unchanged", rd, 32'h8001_2344);
        chk("R2 no downstream cycle", dn_count, 0);
    endtask

    task automatic t_cfg();
        access(1'b0, 'h069, 1, 0, rd, er);
        chk("R3 cycle issued with bit31", dn_count, 1);
        chk("R3 cfg addr OR", cap_addr, 32'h8001_2345);
        chk("R3 is_io=0", {31'd0, cap_io}, 32'd0);
        chk("R6 be byte lane1", {28'd0, cap_be}, 32'h2);
        chk("R7 cfg byte read", rd, 32'h0000_00C3);
        access(1'b0, 'h068, 4, 0, rd, er);
        chk("R7 cfg word read", rd, 32'hA1B2_C3D4);
        chk("R6 be word", {28'd0, cap_be}, 32'hF);
        access(1'b0, 'h06A, 2, 0, rd, er);
        chk("R7 cfg half read", rd, 32'h0000_A1B2);
        access(1'b1, 'h06A, 2, 32'h0000_1234, rd, er);
        chk("R7 cfg half write lanes", cap_wdata, 32'h1234_0000);
        chk("R6 be upper half", {28'd0, cap_be}, 32'hC);
        chk("R3 write flag", {31'd0, cap_we}, 32'd1);
    endtask

    task automatic t_io();
        access(1'b0, 'h06E, 2, 0, rd, er);
        chk("R4 io addr add+trunc", cap_addr, 32'h0000_2346);
        chk("R4 is_io=1", {31'd0, cap_io}, 32'd1);
        chk("R8 io half read", rd, 32'h0000_B2A1);
        access(1'b1, 'h06C, 4, 32'h1122_3344, rd, er);
        chk("R8 io word write lanes", cap_wdata, 32'h4433_2211);
        access(1'b0, 'h06C, 4, 0, rd, er);
        chk("R8 io word read", rd, 32'hD4C3_B2A1);
        access(1'b0, 'h06F, 1, 0, rd, er);
        chk("R8 io byte read", rd, 32'h0000_00A1);
        chk("R6 be lane3", {28'd0, cap_be}, 32'h8);
    endtask

    task automatic t_refuse();
        int base;
        base = dn_count;
        access(1'b0, 'h06D, 2, 0, rd, er); chk("R5 io +1 half", {31'd0, er}, 32'd1);
        access(1'b0, 'h06E, 4, 0, rd, er); chk("R5 io +2 word", {31'd0, er}, 32'd1);
        access(1'b1, 'h06F, 2, 0, rd, er); chk("R5 io +3 half", {31'd0, er}, 32'd1);
        access(1'b0, 'h06C, 3, 0, rd, er); chk("R5 size 3", {31'd0, er}, 32'd1);
        access(1'b0, 'h069, 4, 0, rd, er); chk("R5 cfg +1 word", {31'd0, er}, 32'd1);
        access(1'b0, 'h000, 4, 0, rd, er); chk("R5 unmapped offset", {31'd0, er}, 32'd1);
        chk("R5 no cycle for refused", dn_count, base);
        access(1'b0, 'h06B, 1, 0, rd, er); chk("R5 cfg +3 byte legal", {31'd0, er}, 32'd0);
        chk("R5 legal byte issued", dn_count, base + 1);
    endtask

    task automatic t_wrap();
        access(1'b1, 'h064, 4, 32'h0001_FFFF, rd, er);
        access(1'b0, 'h06F, 1, 0, rd, er);
        chk("R4 io addr truncated", cap_addr, 32'h0000_FFFF);
        access(1'b0, 'h06B, 1, 0, rd, er);
        chk("R3 cfg addr full width", cap_addr, 32'h0001_FFFF);
    endtask

    task automatic t_hold();
        hold_bad  = 1'b0;
        rdy_delay = 3;
        access(1'b0, 'h06C, 4, 0, rd, er);
        rdy_delay = 0;
        chk("R9 request held", {31'd0, hold_bad}, 32'd0);
        chk("R9 busy during cycle", {31'd0, saw_busy}, 32'd1);
        chk("R9 response ok", {31'd0, er}, 32'd0);
        chk("R9 data after delay", rd, 32'hD4C3_B2A1);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        hold_bad = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pointer();
        t_cfg();
        t_io();
        t_refuse();
        t_wrap();
        t_hold();
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule